// File: doc/BRIEF.md
# Indexed accumulator coprocessor

This unit is a small coprocessor that hangs off a CPU's custom-instruction command channel. Each command brings the raw 32-bit instruction word and two 64-bit source operands. The unit keeps a bank of 64-bit accumulators. The instruction's function code picks one of four actions on the accumulator named by the second operand: overwrite it, read it back, add to it, or fill it from memory.

The fill action drives a single-beat read on a simple request/response memory port. The unit waits for the returned word and writes it into the accumulator, and only then takes another command. When the instruction asks for a destination-register write, a response carries the accumulator's resulting value and the instruction's destination register number. The response is held until the CPU takes it.

Top module: `acc_cop`

## Requirements
- R1: A command whose bits [6:0] differ from 7'b0001011 is accepted, changes no accumulator and produces no response.
- R2: Function code 0 (bits [31:25]) stores the first operand into the accumulator selected by the second operand.
- R3: Function code 1 with bit 14 (xd) set returns the selected accumulator's value unchanged on rspData.
- R4: Function code 3 adds the first operand to the selected accumulator, wrapping modulo 2^64.
- R5: Function code 2 raises memReqValid with memReqAddr equal to the first operand, holding both until memReqReady. The word arriving with memRspValid is then stored into the selected accumulator.
- R6: A response is raised only when xd (bit 14) is set. It carries the selected accumulator's value after the operation, and rspRd carries bits [11:7] of the command.
- R7: busy is high from the cycle after an accepted command that needs a memory read or a response until that command completes, and cmdReady equals not busy.
- R8: cmdReady stays low while a memory read is requested or awaited, so no second read can start.
- R9: While rspValid is high and rspReady is low, rspValid, rspData and rspRd stay unchanged.
- R10: After reset all four accumulators read zero, busy is low, cmdReady is high and no request or response is valid.
- R11: Only bits [1:0] of the second operand select the accumulator; higher bits are ignored.
- R12: Function codes 4 to 127 with the correct opcode change no accumulator and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Unit can take a command |
| cmdInst | input | 32 | Raw instruction word |
| cmdRs1 | input | 64 | First source operand |
| cmdRs2 | input | 64 | Second source operand (accumulator index) |
| rspValid | output | 1 | Response offered |
| rspReady | input | 1 | CPU takes the response |
| rspRd | output | 5 | Destination register number |
| rspData | output | 64 | Response value |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory takes the request |
| memReqAddr | output | 64 | Read address |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Returned word |
| busy | output | 1 | A command is still in progress |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that a stalled response or memory request stays stable, that no command is taken while a read is pending, that busy follows an accepted fill, and that a command without xd raises no response. The accumulator arithmetic can only be shown by the bench's scenarios: wrap-around, index aliasing through the high operand bits, fills from memory, and ignored opcodes and function codes. The bench compares read-backs against its own model of the bank.

// File: rtl/acc_cop_pkg.sv
package acc_cop_pkg;
  localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

  typedef enum logic [1:0] {
    SRC_RS1  = 2'd0,
    SRC_HOLD = 2'd1,
    SRC_SUM  = 2'd2,
    SRC_MEM  = 2'd3
  } wrSrc_e;

  typedef struct packed {
    logic   capture;
    logic   accWe;
    wrSrc_e wrSrc;
    logic   rspLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/acc_cop_ctrl.sv
module acc_cop_ctrl
  import acc_cop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [31:0] cmdInst,
  input  logic        rspReady,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        cmdReady,
  output logic        rspValid,
  output logic        memReqValid,
  output logic        busy,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_MEMREQ, S_MEMWAIT, S_RESP} state_e;

  state_e stateQ, stateD;
  logic   xdQ;
  logic   accept, isOp, xdBit;
  logic [6:0] funct;

  assign cmdReady    = (stateQ == S_IDLE);
  assign busy        = (stateQ != S_IDLE);
  assign rspValid    = (stateQ == S_RESP);
  assign memReqValid = (stateQ == S_MEMREQ);
  assign accept      = cmdValid && cmdReady;
  assign isOp        = (cmdInst[6:0] == OPC_CUSTOM0);
  assign xdBit       = cmdInst[14];
  assign funct       = cmdInst[31:25];

  always_comb begin
    stateD         = stateQ;
    strobe         = '0;
    strobe.wrSrc   = SRC_HOLD;
    strobe.capture = accept;
    unique case (stateQ)
      S_IDLE: begin
        if (accept && isOp) begin
          unique case (funct)
            7'd0: begin
              strobe.accWe   = 1'b1;
              strobe.wrSrc   = SRC_RS1;
              strobe.rspLoad = xdBit;
              if (xdBit) stateD = S_RESP;
            end
            7'd1: begin
              strobe.wrSrc   = SRC_HOLD;
              strobe.rspLoad = xdBit;
              if (xdBit) stateD = S_RESP;
            end
            7'd2: stateD = S_MEMREQ;
            7'd3: begin
              strobe.accWe   = 1'b1;
              strobe.wrSrc   = SRC_SUM;
              strobe.rspLoad = xdBit;
              if (xdBit) stateD = S_RESP;
            end
            default: ;
          endcase
        end
      end
      S_MEMREQ: if (memReqReady) stateD = S_MEMWAIT;
      S_MEMWAIT: begin
        if (memRspValid) begin
          strobe.accWe   = 1'b1;
          strobe.wrSrc   = SRC_MEM;
          strobe.rspLoad = xdQ;
          stateD         = xdQ ? S_RESP : S_IDLE;
        end
      end
      S_RESP: if (rspReady) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      xdQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) xdQ <= xdBit;
    end
  end
endmodule

// File: rtl/acc_cop_dpath.sv
module acc_cop_dpath
  import acc_cop_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int NUM_ACC = 4,
  parameter int RD_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] cmdRs1,
  input  logic [DATA_W-1:0] cmdRs2,
  input  logic [RD_W-1:0]   cmdRd,
  input  logic [DATA_W-1:0] memRspData,
  output logic [DATA_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] rspData,
  output logic [RD_W-1:0]   rspRd
);
  localparam int IDX_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1;

  logic [DATA_W-1:0] accQ [NUM_ACC];
  logic [IDX_W-1:0]  idxQ, selIdx;
  logic [DATA_W-1:0] curVal, newVal, addrQ, rspDataQ;
  logic [RD_W-1:0]   rdQ;

  assign selIdx = strobe.capture ? cmdRs2[IDX_W-1:0] : idxQ;
  assign curVal = accQ[selIdx];

  always_comb begin
    unique case (strobe.wrSrc)
      SRC_RS1:  newVal = cmdRs1;
      SRC_SUM:  newVal = curVal + cmdRs1;
      SRC_MEM:  newVal = memRspData;
      default:  newVal = curVal;
    endcase
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rstN)
        accQ[i] <= '0;
      else if (strobe.accWe && (selIdx == IDX_W'(i)))
        accQ[i] <= newVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      addrQ    <= '0;
      rdQ      <= '0;
      rspDataQ <= '0;
    end else begin
      if (strobe.capture) begin
        idxQ  <= cmdRs2[IDX_W-1:0];
        addrQ <= cmdRs1;
        rdQ   <= cmdRd;
      end
      if (strobe.rspLoad) rspDataQ <= newVal;
    end
  end

  assign memReqAddr = addrQ;
  assign rspData    = rspDataQ;
  assign rspRd      = rdQ;
endmodule

// File: rtl/acc_cop.sv
module acc_cop
  import acc_cop_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int NUM_ACC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [31:0]       cmdInst,
  input  logic [DATA_W-1:0] cmdRs1,
  input  logic [DATA_W-1:0] cmdRs2,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [4:0]        rspRd,
  output logic [DATA_W-1:0] rspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [DATA_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              busy
);
  ctrlStrobe_t strobe;

  acc_cop_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdInst     (cmdInst),
    .rspReady    (rspReady),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .cmdReady    (cmdReady),
    .rspValid    (rspValid),
    .memReqValid (memReqValid),
    .busy        (busy),
    .strobe      (strobe)
  );

  acc_cop_dpath #(.DATA_W(DATA_W), .NUM_ACC(NUM_ACC), .RD_W(5)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdRs1     (cmdRs1),
    .cmdRs2     (cmdRs2),
    .cmdRd      (cmdInst[11:7]),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .rspData    (rspData),
    .rspRd      (rspRd)
  );
endmodule

// File: rtl/acc_cop_chk.sv
module acc_cop_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [31:0]       cmdInst,
  input logic              rspValid,
  input logic              rspReady,
  input logic [4:0]        rspRd,
  input logic [DATA_W-1:0] rspData,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [DATA_W-1:0] memReqAddr,
  input logic              busy
);
  logic acceptOp;
  assign acceptOp = cmdValid && cmdReady && (cmdInst[6:0] == 7'b0001011);

  a_r8_one_load: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !cmdReady);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspRd)));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  a_r7_busy_load: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOp && cmdInst[31:25] == 7'd2) |=> (busy && memReqValid));

  a_r6_no_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOp && !cmdInst[14] && cmdInst[31:25] != 7'd2) |=> !rspValid);
endmodule

bind acc_cop acc_cop_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdReady    (cmdReady),
  .cmdInst     (cmdInst),
  .rspValid    (rspValid),
  .rspReady    (rspReady),
  .rspRd       (rspRd),
  .rspData     (rspData),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .busy        (busy)
);

// File: tb/acc_cop_tb_top.sv
module acc_cop_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [31:0] cmdInst = '0;
  logic [63:0] cmdRs1 = '0, cmdRs2 = '0;
  logic        rspValid, rspReady = 1'b0;
  logic [4:0]  rspRd;
  logic [63:0] rspData;
  logic        memReqValid, memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = 64'hDEAD_BEEF_0BAD_F00D;
  logic        busy;

  int checks = 0, errors = 0;
  logic [63:0] model [4];

  always #2.5 clk = ~clk;

  acc_cop dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdInst(cmdInst), .cmdRs1(cmdRs1), .cmdRs2(cmdRs2),
    .rspValid(rspValid), .rspReady(rspReady), .rspRd(rspRd), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .busy(busy)
  );

  function automatic logic [63:0] memWord(input logic [63:0] a);
    return {a[31:0], ~a[63:32]} ^ 64'hA5A5_5A5A_3C3C_C3C3;
  endfunction

  function automatic logic [31:0] mkInst(input logic [6:0] opc, input logic [6:0] fn,
                                         input logic xd, input logic [4:0] rd);
    return {fn, 5'd12, 5'd11, xd, 1'b1, 1'b1, rd, opc};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Issue one command and serve it to completion, checking against the model.
  task automatic runCmd(input logic [6:0] opc, input logic [6:0] fn, input logic xd,
                        input logic [4:0] rd, input logic [63:0] rs1,
                        input logic [63:0] rs2, input int stall);
    bit          isOp = (opc == 7'b0001011) && (fn <= 7'd3);
    bit          isLoad = isOp && (fn == 7'd2);
    bit          wantRsp = isOp && xd;
    int          idx = int'(rs2[1:0]);
    logic [63:0] newVal = model[idx];
    string       tag;
    if (isOp) begin
      case (fn)
        7'd0: newVal = rs1;
        7'd2: newVal = memWord(rs1);
        7'd3: newVal = model[idx] + rs1;
        default: newVal = model[idx];
      endcase
    end
    tag = (opc != 7'b0001011) ? "R1" : (fn > 7'd3) ? "R12" :
          (fn == 7'd0) ? "R2" : (fn == 7'd1) ? "R3" : (fn == 7'd2) ? "R5" : "R4";
    @(negedge clk);
    cmdValid = 1'b1;
    cmdInst  = mkInst(opc, fn, xd, rd);
    cmdRs1   = rs1;
    cmdRs2   = rs2;
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(busy == (isLoad || wantRsp), "R7 busy after accept", 64'(busy), 64'(isLoad || wantRsp));
    if (isLoad) begin
      for (int k = 0; k < stall; k++) begin
        chk(memReqValid && memReqAddr == rs1, "R5 request held", memReqAddr, rs1);
        chk(!cmdReady, "R8 ready low while request", 64'(cmdReady), 64'd0);
        @(negedge clk);
      end
      chk(memReqValid && memReqAddr == rs1, "R5 request address", memReqAddr, rs1);
      memReqReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      memReqReady = 1'b0;
      chk(!memReqValid && !cmdReady && busy, "R8 ready low while waiting",
          {62'd0, memReqValid, cmdReady}, 64'd0);
      for (int k = 0; k < stall; k++) @(negedge clk);
      memRspValid = 1'b1;
      memRspData  = memWord(rs1);
      @(posedge clk);
      @(negedge clk);
      memRspValid = 1'b0;
      memRspData  = 64'hDEAD_BEEF_0BAD_F00D;
    end
    if (wantRsp) begin
      for (int k = 0; k < stall; k++) begin
        chk(rspValid && rspData == newVal && rspRd == rd, "R9 response held", rspData, newVal);
        @(negedge clk);
      end
      chk(rspValid, "R6 response valid", 64'(rspValid), 64'd1);
      chk(rspData == newVal, {tag, " R6 response data"}, rspData, newVal);
      chk(rspRd == rd, "R6 response rd", 64'(rspRd), 64'(rd));
      rspReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rspReady = 1'b0;
    end else begin
      chk(!rspValid, {tag, " R6 no response"}, 64'(rspValid), 64'd0);
    end
    chk(!busy && cmdReady, "R7 idle after completion", 64'(busy), 64'd0);
    if (isOp) model[idx] = newVal;
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < 4; i++) begin
      logic [63:0] exp = model[i];
      runCmd(7'b0001011, 7'd1, 1'b1, 5'(i + 3), {$urandom, 30'd0, 2'(i)}, 64'(i), 0);
      if (model[i] != exp) chk(1'b0, req, model[i], exp);
    end
  endtask

  // R3 / R11 / R12 / R1 effects are confirmed through read-backs below.
  task automatic readCheck(input int i, input logic [63:0] exp, input string req);
    runCmd(7'b0001011, 7'd1, 1'b1, 5'd9, 64'd0, 64'(i), 1);
    chk(model[i] == exp, req, model[i], exp);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(!busy && cmdReady && !rspValid && !memReqValid, "R10 idle after reset",
        {60'd0, busy, cmdReady, rspValid, memReqValid}, 64'b0100);
    for (int i = 0; i < 4; i++) readCheck(i, 64'd0, "R10 accumulator zero");

    // R5 then R4: fill from memory and add
    runCmd(7'b0001011, 7'd2, 1'b0, 5'd0, 64'h8000_0000_0000_3421, 64'd0, 2);
    runCmd(7'b0001011, 7'd3, 1'b0, 5'd0, 64'd2, 64'd0, 0);
    readCheck(0, memWord(64'h8000_0000_0000_3421) + 64'd2, "R5 fill plus add");
    // R2 then R4
    runCmd(7'b0001011, 7'd0, 1'b0, 5'd0, 64'd3, 64'd0, 0);
    runCmd(7'b0001011, 7'd3, 1'b0, 5'd0, 64'd1, 64'd0, 0);
    readCheck(0, 64'd4, "R2 write then R4 add");
    // R4 wrap
    runCmd(7'b0001011, 7'd0, 1'b1, 5'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 3);
    runCmd(7'b0001011, 7'd3, 1'b1, 5'd8, 64'd2, 64'd2, 0);
    readCheck(2, 64'd1, "R4 wrap modulo 2^64");
    // R11: high index bits ignored (5 aliases 1)
    runCmd(7'b0001011, 7'd0, 1'b0, 5'd0, 64'h1111_2222_3333_4444, 64'hF000_0000_0000_0005, 0);
    readCheck(1, 64'h1111_2222_3333_4444, "R11 index alias");
    // R1: wrong opcode ignored
    runCmd(7'b0101011, 7'd0, 1'b1, 5'd1, 64'h5555, 64'd1, 0);
    readCheck(1, 64'h1111_2222_3333_4444, "R1 wrong opcode ignored");
    // R12: unused function code ignored
    runCmd(7'b0001011, 7'd77, 1'b1, 5'd1, 64'h6666, 64'd1, 0);
    readCheck(1, 64'h1111_2222_3333_4444, "R12 unused funct ignored");
    // R5 with response and long stalls
    runCmd(7'b0001011, 7'd2, 1'b1, 5'd31, 64'h0123_4567_89AB_CDEF, 64'd3, 5);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int          r = int'($urandom_range(0, 99));
      logic [6:0]  opc = (r < 5) ? 7'b1011011 : 7'b0001011;
      logic [6:0]  fn = (r >= 5 && r < 10) ? 7'($urandom_range(4, 127))
                                           : 7'($urandom_range(0, 3));
      logic        xd = (fn == 7'd1) ? 1'b1 : 1'($urandom);
      logic [63:0] rs1 = {$urandom, $urandom};
      logic [63:0] rs2 = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) rs1 = 64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom_range(0, 15));
      runCmd(opc, fn, xd, 5'($urandom), rs1, rs2, int'($urandom_range(0, 3)));
      if (n % 50 == 49) readAll("R3 random read-back");
    end
    readAll("R3 final read-back");
    finishRun();
  end
endmodule